// File: doc/BRIEF.md
# Drive Select and Motor Sequencer

This block controls the select line and the motor-enable line of one disk drive. A host issues one command at a time: select, deselect, motor on, motor off or bus reset. The block updates the lines, waits the settling time the command needs, and then gives a one-cycle acknowledge. The settling times for select and for motor spin-up are given in clock cycles on two configuration inputs. They are captured when a command is accepted.

Both drive lines are active-low and open-drain in style. A value of 0 means the line is pulled low, which is the asserted state. A value of 1 means the line is released. A motor command that asks for the state already in effect finishes at once and leaves the line alone. Only switching the motor from off to on waits for spin-up. Switching it off finishes with no delay. A bus reset releases both lines and leaves the motor recorded as off.

Top module: `dsel_motor_seq`

## Requirements
- R1: After synchronous reset, `sel_n` and `mot_n` are 1 (released), `busy` is 0, `ack` is 0, and the motor is recorded as off.
- R2: A command is accepted only on a clock edge where `cmd_valid` is 1, `busy` is 0 and the opcode is legal. Commands presented while `busy` is 1 do not change the lines, and they do not change the acknowledge timing.
- R3: Select (`cmd_op`=1) pulls `sel_n` low at the accepting edge. `ack` then rises at the (S+1)th clock edge after acceptance, where S is `sel_dly_cyc`. This wait applies even if the drive is already selected.
- R4: Deselect (`cmd_op`=2) releases `sel_n` (no unit selected) and acknowledges at the 1st edge after acceptance.
- R5: Motor on (`cmd_op`=3) while the motor is off pulls `mot_n` low at the accepting edge. `ack` then rises at the (M+1)th edge after acceptance, where M is `mot_dly_cyc`.
- R6: Motor on while the motor is on, or motor off (`cmd_op`=4) while it is off, leaves `mot_n` unchanged and acknowledges at the 1st edge after acceptance.
- R7: Motor off while the motor is on releases `mot_n` and acknowledges at the 1st edge after acceptance.
- R8: Bus reset (`cmd_op`=5) releases both lines and acknowledges at the 1st edge after acceptance. A later motor-on command waits the full spin-up delay.
- R9: `busy` is 1 from the accepting edge until the acknowledge cycle. `ack` is high for exactly one cycle, and `busy` is 0 during that cycle.
- R10: A programmed delay of zero acknowledges at the 1st edge after acceptance.
- R11: Opcodes 0, 6 and 7 are never accepted. They cause no `busy`, no `ack` and no change to the lines.
- R12: The delay value is sampled at acceptance. Changing `sel_dly_cyc` or `mot_dly_cyc` while `busy` is 1 does not alter the current wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Opcode: 1 select, 2 deselect, 3 motor on, 4 motor off, 5 bus reset |
| sel_dly_cyc | input | 24 | Select settling delay in cycles |
| mot_dly_cyc | input | 24 | Motor spin-up delay in cycles |
| busy | output | 1 | Command in progress |
| ack | output | 1 | One-cycle completion pulse |
| sel_n | output | 1 | Drive select line, 0 = pulled low (asserted) |
| mot_n | output | 1 | Motor enable line, 0 = pulled low (asserted) |

## Verification
The properties assume that a command is only counted when it is presented while `busy` is low. They also assume that `cmd_op` is stable during that edge. The bench drives every input on the falling clock edge. It holds `cmd_valid` for a single cycle per command, except in the busy-collision scenario, which deliberately presents a second command during a wait. Delays are kept small, so every settling window fits in a short directed test.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    localparam int DLY_W = 24;
    localparam int N_LINES = 2;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_SELECT    = 3'd1,
        OP_DESELECT  = 3'd2,
        OP_MOTOR_ON  = 3'd3,
        OP_MOTOR_OFF = 3'd4,
        OP_BUS_RESET = 3'd5
    } dsm_op_e;

    // Internal line state: 1 = asserted (pin pulled low)
    typedef struct packed {
        logic sel;
        logic mot;
    } dsm_lines_t;

    function automatic logic op_legal(input logic [2:0] op);
        return (op >= 3'd1) && (op <= 3'd5);
    endfunction

    function automatic dsm_lines_t next_lines(input dsm_op_e op, input dsm_lines_t cur);
        dsm_lines_t n;
        n = cur;
        case (op)
            OP_SELECT:    n.sel = 1'b1;
            OP_DESELECT:  n.sel = 1'b0;
            OP_MOTOR_ON:  n.mot = 1'b1;
            OP_MOTOR_OFF: n.mot = 1'b0;
            OP_BUS_RESET: begin
                n.sel = 1'b0;
                n.mot = 1'b0;
            end
            default: n = cur;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dsm_timer.sv
module dsm_timer #(
    parameter int W = dsm_pkg::DLY_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;
    logic         run_q;

    assign expired = run_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            run_q <= 1'b1;
        end else if (expired) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/dsm_od_out.sv
module dsm_od_out #(
    parameter int N = dsm_pkg::N_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic [N-1:0] nxt_asserted,
    output logic [N-1:0] cur_asserted,
    output logic [N-1:0] pin_n
);
    logic [N-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (upd) q <= nxt_asserted;
    end

    assign cur_asserted = q;

    // Open-drain style: asserted drives low, released reads high
    for (genvar i = 0; i < N; i++) begin : g_pin
        assign pin_n[i] = ~q[i];
    end

endmodule

// File: rtl/dsel_motor_seq.sv
module dsel_motor_seq
    import dsm_pkg::*;
#(
    parameter int DW = DLY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] sel_dly_cyc,
    input  logic [DW-1:0] mot_dly_cyc,
    output logic          busy,
    output logic          ack,
    output logic          sel_n,
    output logic          mot_n
);
    dsm_op_e    op;
    logic       legal;
    logic       accept;
    logic       expired;
    dsm_lines_t cur_l;
    dsm_lines_t nxt_l;
    logic [DW-1:0] wait_cyc;
    logic [N_LINES-1:0] pins_n;
    logic busy_q, ack_q;

    assign op     = dsm_op_e'(cmd_op);
    assign legal  = op_legal(cmd_op);
    assign accept = cmd_valid && !busy_q && legal;
    assign nxt_l  = next_lines(op, cur_l);

    always_comb begin
        wait_cyc = '0;
        if (op == OP_SELECT)
            wait_cyc = sel_dly_cyc;
        else if (op == OP_MOTOR_ON && !cur_l.mot)
            wait_cyc = mot_dly_cyc;
    end

    dsm_od_out #(.N(N_LINES)) u_lines (
        .clk          (clk),
        .rst          (rst),
        .upd          (accept),
        .nxt_asserted (nxt_l),
        .cur_asserted (cur_l),
        .pin_n        (pins_n)
    );

    dsm_timer #(.W(DW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (wait_cyc),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            ack_q <= expired;
            if (accept)       busy_q <= 1'b1;
            else if (expired) busy_q <= 1'b0;
        end
    end

    assign busy  = busy_q;
    assign ack   = ack_q;
    assign sel_n = pins_n[1];
    assign mot_n = pins_n[0];

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R9
    AST_BUSY_END_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ack); // R9
    AST_ACK_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(busy)); // R9
    AST_LINES_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(sel_n) && $stable(mot_n))); // R2
    AST_ILLEGAL_NOP: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && !legal) |=> !busy); // R11
    AST_SEL_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_SELECT) |=> !sel_n); // R3
    AST_RESET_LINES: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_BUS_RESET) |=> (sel_n && mot_n)); // R8
    AST_OFF_FAST: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_MOTOR_OFF) |-> ##2 ack); // R7

endmodule

// File: tb/tb_dsel_motor_seq.sv
module tb_dsel_motor_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [23:0] sel_dly_cyc = 24'd5;
    logic [23:0] mot_dly_cyc = 24'd12;
    logic busy, ack, sel_n, mot_n;
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    dsel_motor_seq dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .sel_dly_cyc(sel_dly_cyc), .mot_dly_cyc(mot_dly_cyc),
        .busy(busy), .ack(ack), .sel_n(sel_n), .mot_n(mot_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one command; optionally inject a second command and a delay
    // change while busy. Checks latency, busy and line levels.
    task automatic run_cmd(input string req, input logic [2:0] op, input int exp_lat,
                           input int exp_sel_n, input int exp_mot_n, input bit inject);
        int lat = 0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        check({req, " busy after accept"}, busy, 1);
        while (!ack && lat < 500) begin
            @(negedge clk);
            lat++;
            if (inject && lat == 1) begin
                cmd_valid   = 1'b1;
                cmd_op      = 3'd2;
                sel_dly_cyc = 24'd30;
                mot_dly_cyc = 24'd30;
            end else if (inject && lat == 2) begin
                cmd_valid = 1'b0;
            end
        end
        check({req, " ack latency"}, lat, exp_lat);
        check({req, " busy low at ack"}, busy, 0);
        check({req, " sel_n"}, sel_n, exp_sel_n);
        check({req, " mot_n"}, mot_n, exp_mot_n);
        @(negedge clk);
        check({req, " ack one cycle"}, ack, 0);
    endtask

    task automatic t_reset();
        check("R1 sel_n", sel_n, 1);
        check("R1 mot_n", mot_n, 1);
        check("R1 busy", busy, 0);
        check("R1 ack", ack, 0);
    endtask

    task automatic t_select();
        sel_dly_cyc = 24'd5;
        run_cmd("R3 R9 select", 3'd1, 6, 0, 1, 1'b0);
        run_cmd("R3 reselect", 3'd1, 6, 0, 1, 1'b0);
    endtask

    task automatic t_zero();
        sel_dly_cyc = 24'd0;
        run_cmd("R10 zero delay", 3'd1, 1, 0, 1, 1'b0);
        sel_dly_cyc = 24'd5;
    endtask

    task automatic t_deselect();
        run_cmd("R4 deselect", 3'd2, 1, 1, 1, 1'b0);
    endtask

    task automatic t_motor();
        mot_dly_cyc = 24'd12;
        run_cmd("R6 off when off", 3'd4, 1, 1, 1, 1'b0);
        run_cmd("R5 motor on", 3'd3, 13, 1, 0, 1'b0);
        run_cmd("R6 on when on", 3'd3, 1, 1, 0, 1'b0);
        run_cmd("R7 motor off", 3'd4, 1, 1, 1, 1'b0);
    endtask

    task automatic t_busy_collide();
        sel_dly_cyc = 24'd5;
        run_cmd("R2 R12 collide", 3'd1, 6, 0, 1, 1'b1);
        sel_dly_cyc = 24'd5;
        mot_dly_cyc = 24'd12;
    endtask

    task automatic t_illegal();
        logic [2:0] bad [3] = '{3'd0, 3'd6, 3'd7};
        for (int i = 0; i < 3; i++) begin
            int seen_busy = 0;
            int seen_ack = 0;
            @(negedge clk);
            cmd_valid = 1'b1;
            cmd_op    = bad[i];
            @(negedge clk);
            cmd_valid = 1'b0;
            for (int k = 0; k < 4; k++) begin
                if (busy) seen_busy = 1;
                if (ack)  seen_ack = 1;
                @(negedge clk);
            end
            check("R11 illegal busy", seen_busy, 0);
            check("R11 illegal ack", seen_ack, 0);
            check("R11 illegal sel_n", sel_n, 0);
            check("R11 illegal mot_n", mot_n, 1);
        end
    endtask

    task automatic t_bus_reset();
        run_cmd("R5 spin before reset", 3'd3, 13, 0, 0, 1'b0);
        run_cmd("R8 bus reset", 3'd5, 1, 1, 1, 1'b0);
        run_cmd("R8 spin after reset", 3'd3, 13, 1, 0, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_select();
        t_zero();
        t_deselect();
        t_motor();
        t_busy_collide();
        t_illegal();
        t_bus_reset();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule